// File: doc/BRIEF.md
# Raster Timing and Framebuffer Address Generator

This block produces the line and frame timing for a non-interlaced 50 Hz display. The pixel clock runs at 10 MHz and is presented as a clock enable, so each enabled cycle lasts one 0.1 us pixel. A 640-count horizontal counter gives a 64 us line, which is a 15625 Hz line rate. A 312-count vertical counter gives one frame of roughly 20 ms.

The visible window is 512 pixels by 256 lines and starts at count zero of both counters. Because of this, the screen memory address is taken straight from the counter bits and no separate address counter is needed:
- The low line-counter bits and the low pixel-counter bits together form the pixel address.
- The bottom two address bits pick a 2-bit pixel inside a byte.
- The remaining bits give a 15-bit byte address.

Blanking comes only from the top bit of each counter. Each counter's terminal count is found by checking only the bits that are set in its period.

A small serializer takes a byte from screen memory on the last pixel slot of each byte. The memory read is combinational from `byte_addr`. The serializer then emits that byte's four 2-bit pixels over the next four slots, most significant pair first. The pixel output is forced to zero whenever the raster is blanked.

Top module: `raster_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both counters go to 0, the serializer byte goes to 0, and `hsync`, `vsync`, `byte_addr`, `pix_idx` and `pixel` are all 0 afterwards.
- R2: The horizontal count advances by one on each edge where `pix_en` is high. It runs 0 to H_TOTAL-1 (639), then returns to 0.
- R3: The vertical count advances by one on each edge where the horizontal count returns to 0. It runs 0 to V_TOTAL-1 (311), then returns to 0.
- R4: On an edge where `pix_en` is low, no output and no counter changes.
- R5: `byte_addr` equals {vertical count bits 7:0, horizontal count bits 8:2}, and `pix_idx` equals horizontal count bits 1:0.
- R6: `blank` is 1 exactly when horizontal count bit 9 or vertical count bit 8 is 1, i.e. h >= 512 or v >= 256.
- R7: `hsync` is 1 exactly for horizontal counts 560 to 606 inclusive (47 pixels).
- R8: `vsync` is 1 exactly for vertical counts 280 to 282 inclusive (3 lines).
- R9: On an enabled edge with `pix_idx` = 3, the serializer loads `rd_data` if not blanked, or 0 if blanked. While the next byte's slots pass, `pixel` with `pix_idx` = k shows loaded bits [7-2k : 6-2k].
- R10: `pixel` is 0 whenever `blank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | One-pixel clock enable (10 MHz rate) |
| rd_data | input | 8 | Screen memory byte at `byte_addr` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Raster outside the visible window |
| byte_addr | output | 15 | Screen memory byte address |
| pix_idx | output | 2 | Pixel slot within the current byte |
| pixel | output | 2 | Serialized 2-bit pixel, zero when blanked |

## Verification
Two events can fall on the same enabled edge:
- The line wrap and the frame wrap coincide at the last pixel of line 311.
- At that same pixel, slot 3 triggers a serializer load during blanking.

The bench drives a reduced configuration through whole frames, both with the enable held high and with a gapped enable pattern. Every cycle is compared against counters and a shift byte modelled arithmetically from the requirements. The cycles right after the combined wrap are judged by the address returning to 0 and the first visible byte of the new frame showing pixel 0.

// File: rtl/raster_gen.sv
module raster_gen #(
  parameter int H_BITS   = 10,
  parameter int V_BITS   = 9,
  parameter int H_TOTAL  = 640,
  parameter int V_TOTAL  = 312,
  parameter int HS_START = 560,
  parameter int HS_LEN   = 47,
  parameter int VS_START = 280,
  parameter int VS_LEN   = 3,
  localparam int AW = (V_BITS - 1) + (H_BITS - 1) - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [7:0]    rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic [AW-1:0] byte_addr,
  output logic [1:0]    pix_idx,
  output logic [1:0]    pixel
);

  localparam logic [H_BITS-1:0] HT    = H_BITS'(H_TOTAL);
  localparam logic [V_BITS-1:0] VT    = V_BITS'(V_TOTAL);
  localparam logic [H_BITS-1:0] HS_LO = H_BITS'(HS_START);
  localparam logic [H_BITS-1:0] HS_HI = H_BITS'(HS_START + HS_LEN - 1);
  localparam logic [V_BITS-1:0] VS_LO = V_BITS'(VS_START);
  localparam logic [V_BITS-1:0] VS_HI = V_BITS'(VS_START + VS_LEN - 1);

  logic [H_BITS-1:0] hcnt, h_inc;
  logic [V_BITS-1:0] vcnt, v_inc;
  logic [7:0]        shreg;
  logic              h_wrap, v_wrap;

  // terminal counts: only the bits set in the period are examined
  assign h_inc  = hcnt + H_BITS'(1);
  assign v_inc  = vcnt + V_BITS'(1);
  assign h_wrap = (h_inc & HT) == HT;
  assign v_wrap = (v_inc & VT) == VT;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_en) begin
      hcnt <= h_wrap ? '0 : h_inc;
      if (h_wrap) vcnt <= v_wrap ? '0 : v_inc;
    end
  end

  assign blank     = hcnt[H_BITS-1] | vcnt[V_BITS-1];
  assign byte_addr = {vcnt[V_BITS-2:0], hcnt[H_BITS-2:2]};
  assign pix_idx   = hcnt[1:0];
  assign hsync     = ~rst & (hcnt >= HS_LO) & (hcnt <= HS_HI);
  assign vsync     = ~rst & (vcnt >= VS_LO) & (vcnt <= VS_HI);

  always_ff @(posedge clk) begin
    if (rst)
      shreg <= '0;
    else if (pix_en && pix_idx == 2'd3)
      shreg <= blank ? 8'd0 : rd_data;
  end

  always_comb begin
    case (pix_idx)
      2'd0:    pixel = shreg[7:6];
      2'd1:    pixel = shreg[5:4];
      2'd2:    pixel = shreg[3:2];
      default: pixel = shreg[1:0];
    endcase
    if (blank) pixel = 2'd0;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (hcnt == '0 && vcnt == '0 && !hsync && !vsync));

  assert_hwrap_R2: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt == HT - H_BITS'(1)) |=> hcnt == '0);

  assert_hrange_R2: assert property (@(posedge clk) disable iff (rst)
    hcnt < HT);

  assert_vstep_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt == HT - H_BITS'(1) && vcnt != VT - V_BITS'(1))
      |=> vcnt == $past(vcnt) + V_BITS'(1));

  assert_vwrap_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt == HT - H_BITS'(1) && vcnt == VT - V_BITS'(1)) |=> vcnt == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(hcnt) && $stable(vcnt) && $stable(shreg)));

  assert_hsync_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> hcnt == HS_LO);

  assert_vsync_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (vcnt == VS_LO && hcnt == '0));

endmodule

// File: tb/test_raster_gen.sv
module test_raster_gen;
  localparam int HB = 6, VB = 5, HT = 40, VT = 20;
  localparam int HSS = 34, HSL = 3, VSS = 17, VSL = 2;
  localparam int AW = (VB - 1) + (HB - 1) - 2;
  localparam int HVIS = 1 << (HB - 1), VVIS = 1 << (VB - 1);

  logic clk = 0, rst = 1, pix_en = 0;
  logic [7:0] rd_data;
  logic hsync, vsync, blank;
  logic [AW-1:0] byte_addr;
  logic [1:0] pix_idx, pixel;

  int checks = 0, failures = 0;
  int m_h = 0, m_v = 0, m_sh = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic int memf(int a);
    return (a * 73 + 29) & 255;
  endfunction

  assign rd_data = 8'(memf(int'(byte_addr)));

  raster_gen #(.H_BITS(HB), .V_BITS(VB), .H_TOTAL(HT), .V_TOTAL(VT),
               .HS_START(HSS), .HS_LEN(HSL), .VS_START(VSS), .VS_LEN(VSL)) i_raster_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .blank(blank), .byte_addr(byte_addr),
    .pix_idx(pix_idx), .pixel(pixel));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", req, m_h, m_v, act, exp);
    end
  endtask

  function automatic int m_addr();
    return ((m_v % VVIS) << (HB - 3)) | ((m_h % HVIS) >> 2);
  endfunction

  function automatic bit m_blank();
    return (m_h >= HVIS) || (m_v >= VVIS);
  endfunction

  task automatic check_all();
    int idx = m_h & 3;
    int pe;
    pe = m_blank() ? 0 : ((m_sh >> (6 - 2 * idx)) & 3);
    chk("R5 addr", int'(byte_addr), m_addr());
    chk("R5 idx", int'(pix_idx), idx);
    chk("R6 blank", int'(blank), int'(m_blank()));
    chk("R7 hsync", int'(hsync), int'(m_h >= HSS && m_h < HSS + HSL));
    chk("R8 vsync", int'(vsync), int'(m_v >= VSS && m_v < VSS + VSL));
    chk(m_blank() ? "R10 pixel" : "R9 pixel", int'(pixel), pe);
  endtask

  // one clock: check current state at negedge, apply en, then advance model (R2 R3 R4)
  task automatic step(bit en);
    check_all();
    pix_en = en;
    if (en) begin
      if ((m_h & 3) == 3) m_sh = m_blank() ? 0 : memf(m_addr());
      if (m_h == HT - 1) begin
        m_h = 0;
        m_v = (m_v == VT - 1) ? 0 : m_v + 1;
      end else m_h++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1;
    pix_en = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addr", int'(byte_addr), 0);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 pixel", int'(pixel), 0);
    chk("R1 idx", int'(pix_idx), 0);
    rst = 0;
    // R2 R3: two full frames with enable held high, covering the combined wrap
    for (int c = 0; c < 2 * HT * VT + 5; c++) step(1'b1);
    // R4: gapped enable over more than a frame
    for (int c = 0; c < 3 * HT * VT / 2; c++) step((c % 3) != 1);
    // R4: long hold, outputs must not move
    for (int c = 0; c < 50; c++) step(1'b0);
    // R1: reset mid-frame, then resume
    rst = 1;
    pix_en = 1;
    @(negedge clk);
    m_h = 0; m_v = 0; m_sh = 0;
    chk("R1 addr mid", int'(byte_addr), 0);
    chk("R1 pixel mid", int'(pixel), 0);
    rst = 0;
    for (int c = 0; c < HT * VT + 10; c++) step((c % 5) != 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule